// File: doc/BRIEF.md
# Serial Transceiver with Automatic RTS/CTS Flow Control

This block is a single-channel asynchronous serial transmitter and receiver (8 data bits, no parity, one stop bit) with hardware flow control in both directions. A host writes bytes into a one-entry transmit holding register and reads bytes from a receive FIFO whose depth is a build parameter (8 or 16). Three mode bits, written in a single host write, decide whether the transmitter obeys the active-low clear-to-send input and whether the active-low request-to-send output is driven by the receiver or by a software-set level.

When the receiver owns request-to-send, the pin is negated only at one moment: the receive FIFO is already full and the start bit of one more character has been validated. That character is still shifted in and kept in a one-entry holding stage, so the receiver ends up owning FIFO depth plus one characters. When the transmitter obeys clear-to-send, it looks at the synchronized input only while idle, so a character already on the line always finishes. Wiring the block's request-to-send to a far-end clear-to-send closes the loop on one wire.

The receiver oversamples the line 16 times per bit and accepts a start bit only if the line is still low at mid-bit. The sample rate comes from a clock divider set by a parameter.

Top module: `uart_flow_top`

## Requirements
- R1: After reset, txd_o is high, rtsn_o is high, rx_valid_o is low and tx_hold_full_o is low.
- R2: A frame on txd_o is one low start bit, eight data bits least significant first and one high stop bit, each bit lasting 16*CLK_PER_SAMPLE clocks; a byte written while tx_hold_full_o is low is sent, and bytes looped from txd_o to rxd_i come out of rx_data_o in write order.
- R3: The receiver rechecks a falling edge at mid start bit; a low pulse shorter than half a bit yields no byte, while a well-formed frame driven on rxd_i is received.
- R4: A write on mode_wr_i loads mode_data_i: bit 0 enables clear-to-send gating, bit 1 gives rtsn_o to the receiver, bit 2 is the manual request level (1 drives rtsn_o low).
- R5: With mode bit 1 clear, rtsn_o equals the inverse of mode bit 2 from the cycle after the mode write on.
- R6: With mode bit 0 clear, a high ctsn_i does not stop transmission.
- R7: With mode bit 0 set and ctsn_i high, no new character starts and txd_o stays high; once ctsn_i goes low the pending byte is sent.
- R8: Negating ctsn_i while a character is being shifted out does not cut it short; the following byte waits in the holding register.
- R9: With mode bit 1 set, rtsn_o goes high only when the receive FIFO is full and the start bit of a further character is validated; that character is still received and held.
- R10: rtsn_o returns low in the cycle after a host read from a full FIFO, and the held character moves into the freed slot in the same cycle.
- R11: With rtsn_o wired to ctsn_i and both mode bits 0 and 1 set, no byte is lost or reordered however long the host delays its reads.
- R12: With reads withheld, the receiver holds exactly RX_DEPTH+1 characters, so the stall follows the FIFO depth parameter (8 or 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr_i | input | 1 | Write strobe for the transmit holding register |
| tx_data_i | input | 8 | Byte to transmit |
| tx_hold_full_o | output | 1 | Holding register occupied; writes are ignored while high |
| rx_rd_i | input | 1 | Read strobe; removes the byte on rx_data_o |
| rx_data_o | output | 8 | Oldest received byte |
| rx_valid_o | output | 1 | Receive FIFO not empty |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_data_i | input | 3 | Mode bits: 0 CTS gating, 1 receiver RTS, 2 manual RTS level |
| txd_o | output | 1 | Serial transmit line, idle high |
| rxd_i | input | 1 | Serial receive line, idle high |
| rtsn_o | output | 1 | Request to send, active low |
| ctsn_i | input | 1 | Clear to send, active low, asynchronous |

## Verification
Mode writes take effect at the next clock edge, so the manual request level is compared against the bench's own mode model on every falling clock edge from the cycle after the write. Serial results are slow: a byte lands in the FIFO about ten bit times (160 sample ticks) after its transmit start, and transmit bits are sampled at the middle of each bit period measured from the observed falling start edge. The stall is checked only after a settle time of several character times, and request-to-send reassertion is sampled at the first falling edge after the clock edge that took the read.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;
  localparam int OVS = 16;
  typedef enum logic [1:0] {LN_IDLE, LN_START, LN_DATA, LN_STOP} line_st_e;
endpackage

// File: rtl/uart_flow_tick.sv
module uart_flow_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q == CW'(DIV - 1));
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart_flow_tx.sv
module uart_flow_tx
  import uart_flow_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              gate_en_i,
  input  logic              ctsn_i,
  output logic              hold_full_o,
  output logic              txd_o
);
  localparam int BW = $clog2(DATA_W);

  line_st_e          st_q, st_d;
  logic [3:0]        sub_q, sub_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [DATA_W-1:0] shf_q, shf_d, hd_q, hd_d;
  logic              hv_q, hv_d, txd_q, txd_d;
  logic              cts_s1_q, cts_s2_q;
  logic              cts_ok;

  always_comb begin
    st_d  = st_q;
    sub_d = sub_q;
    bit_d = bit_q;
    shf_d = shf_q;
    txd_d = txd_q;
    hv_d  = hv_q;
    hd_d  = hd_q;
    cts_ok = !gate_en_i || !cts_s2_q;
    if (wr_i && !hv_q) begin
      hv_d = 1'b1;
      hd_d = din_i;
    end
    if (st_q == LN_IDLE) begin
      if (tick_i && hv_q && cts_ok) begin
        st_d  = LN_START;
        shf_d = hd_q;
        sub_d = '0;
        txd_d = 1'b0;
        hv_d  = 1'b0;
      end
    end else if (tick_i) begin
      if (sub_q == 4'(OVS - 1)) begin
        sub_d = '0;
        unique case (st_q)
          LN_START: begin
            st_d  = LN_DATA;
            bit_d = '0;
            txd_d = shf_q[0];
          end
          LN_DATA: begin
            if (bit_q == BW'(DATA_W - 1)) begin
              st_d  = LN_STOP;
              txd_d = 1'b1;
            end else begin
              shf_d = shf_q >> 1;
              txd_d = shf_q[1];
              bit_d = bit_q + 1'b1;
            end
          end
          default: begin
            st_d  = LN_IDLE;
            txd_d = 1'b1;
          end
        endcase
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= LN_IDLE;
      sub_q    <= '0;
      bit_q    <= '0;
      shf_q    <= '0;
      txd_q    <= 1'b1;
      hv_q     <= 1'b0;
      hd_q     <= '0;
      cts_s1_q <= 1'b1;
      cts_s2_q <= 1'b1;
    end else begin
      st_q     <= st_d;
      sub_q    <= sub_d;
      bit_q    <= bit_d;
      shf_q    <= shf_d;
      txd_q    <= txd_d;
      hv_q     <= hv_d;
      hd_q     <= hd_d;
      cts_s1_q <= ctsn_i;
      cts_s2_q <= cts_s1_q;
    end
  end

  assign hold_full_o = hv_q;
  assign txd_o       = txd_q;

  // R7: a negated, gated clear-to-send keeps the transmitter idle
  a_r7_cts_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LN_IDLE && gate_en_i && cts_s2_q) |=> (st_q == LN_IDLE));
  // R8: once data bits are on the line the character is never abandoned
  a_r8_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LN_DATA) |=> (st_q != LN_IDLE));
  // R2: idle line is high
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LN_IDLE) |-> txd_o);
endmodule

// File: rtl/uart_flow_rx.sv
module uart_flow_rx
  import uart_flow_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rxd_i,
  output logic              start_o,
  output logic              byte_v_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam int BW  = $clog2(DATA_W);
  localparam int MID = OVS / 2 - 2;

  line_st_e          st_q, st_d;
  logic [3:0]        sub_q, sub_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [DATA_W-1:0] shf_q, shf_d;
  logic              s1_q, s2_q;
  logic              start_q, start_d, bv_q, bv_d;

  always_comb begin
    st_d    = st_q;
    sub_d   = sub_q;
    bit_d   = bit_q;
    shf_d   = shf_q;
    start_d = 1'b0;
    bv_d    = 1'b0;
    if (tick_i) begin
      unique case (st_q)
        LN_IDLE: begin
          if (!s2_q) begin
            st_d  = LN_START;
            sub_d = '0;
          end
        end
        LN_START: begin
          if (sub_q == 4'(MID)) begin
            sub_d = '0;
            if (s2_q) begin
              st_d = LN_IDLE;
            end else begin
              st_d    = LN_DATA;
              bit_d   = '0;
              start_d = 1'b1;
            end
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
        LN_DATA: begin
          if (sub_q == 4'(OVS - 1)) begin
            sub_d = '0;
            shf_d = {s2_q, shf_q[DATA_W-1:1]};
            bit_d = bit_q + 1'b1;
            if (bit_q == BW'(DATA_W - 1)) st_d = LN_STOP;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
        default: begin
          if (sub_q == 4'(OVS - 1)) begin
            sub_d = '0;
            st_d  = LN_IDLE;
            bv_d  = s2_q;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= LN_IDLE;
      sub_q   <= '0;
      bit_q   <= '0;
      shf_q   <= '0;
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      start_q <= 1'b0;
      bv_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      sub_q   <= sub_d;
      bit_q   <= bit_d;
      shf_q   <= shf_d;
      s1_q    <= rxd_i;
      s2_q    <= s1_q;
      start_q <= start_d;
      bv_q    <= bv_d;
    end
  end

  assign start_o  = start_q;
  assign byte_v_o = bv_q;
  assign byte_o   = shf_q;

  // R3: a line that is high again at mid start bit aborts the frame
  a_r3_glitch_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LN_START && tick_i && sub_q == 4'(MID) && s2_q) |=> (st_q == LN_IDLE && !start_o));
  // R2: a byte is delivered only when leaving the stop bit
  a_r2_byte_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    byte_v_o |-> $past(st_q == LN_STOP));
endmodule

// File: rtl/uart_flow_fifo.sv
module uart_flow_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]       cnt_q, cnt_d;
  logic              do_push, do_pop;

  always_comb begin
    empty_o = (cnt_q == '0);
    full_o  = (cnt_q == (AW+1)'(DEPTH));
    do_pop  = pop_i && !empty_o;
    do_push = push_i && (!full_o || do_pop);
    wp_d    = wp_q;
    rp_d    = rp_q;
    cnt_d   = cnt_q;
    if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= din_i;
  end

  assign dout_o = mem_q[rp_q];

  // R12: occupancy never passes the configured depth
  a_r12_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (AW+1)'(DEPTH));
  // R10: a push into a full FIFO is only legal alongside a pop
  a_r10_full_push_needs_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o) |-> pop_i);
endmodule

// File: rtl/uart_flow_top.sv
module uart_flow_top #(
  parameter int CLK_PER_SAMPLE = 4,
  parameter int RX_DEPTH       = 8,
  parameter int DATA_W         = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_hold_full_o,
  input  logic              rx_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              mode_wr_i,
  input  logic [2:0]        mode_data_i,
  output logic              txd_o,
  input  logic              rxd_i,
  output logic              rtsn_o,
  input  logic              ctsn_i
);
  logic              tick;
  logic              cts_en_q, rx_ctl_q, man_q;
  logic              rx_start, rx_bv;
  logic [DATA_W-1:0] rx_byte;
  logic              held_v_q, held_v_d;
  logic [DATA_W-1:0] held_d_q, held_d_d;
  logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic              rts_flag_q, rts_flag_d;

  uart_flow_tick #(.DIV(CLK_PER_SAMPLE)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  uart_flow_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_i(tx_wr_i), .din_i(tx_data_i),
    .gate_en_i(cts_en_q), .ctsn_i(ctsn_i), .hold_full_o(tx_hold_full_o), .txd_o(txd_o)
  );

  uart_flow_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rxd_i(rxd_i),
    .start_o(rx_start), .byte_v_o(rx_bv), .byte_o(rx_byte)
  );

  uart_flow_fifo #(.DEPTH(RX_DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(fifo_push), .din_i(held_d_q), .pop_i(fifo_pop),
    .dout_o(rx_data_o), .empty_o(fifo_empty), .full_o(fifo_full)
  );

  always_comb begin
    fifo_pop  = rx_rd_i && !fifo_empty;
    fifo_push = held_v_q && (!fifo_full || fifo_pop);
    held_v_d  = held_v_q;
    held_d_d  = held_d_q;
    if (fifo_push) held_v_d = 1'b0;
    if (rx_bv && (!held_v_q || fifo_push)) begin
      held_v_d = 1'b1;
      held_d_d = rx_byte;
    end
    rts_flag_d = rts_flag_q;
    if (rx_start && fifo_full) rts_flag_d = 1'b1;
    else if (fifo_pop)         rts_flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_en_q   <= 1'b0;
      rx_ctl_q   <= 1'b0;
      man_q      <= 1'b0;
      held_v_q   <= 1'b0;
      held_d_q   <= '0;
      rts_flag_q <= 1'b0;
    end else begin
      if (mode_wr_i) begin
        cts_en_q <= mode_data_i[0];
        rx_ctl_q <= mode_data_i[1];
        man_q    <= mode_data_i[2];
      end
      held_v_q   <= held_v_d;
      held_d_q   <= held_d_d;
      rts_flag_q <= rts_flag_d;
    end
  end

  assign rx_valid_o = !fifo_empty;
  assign rtsn_o     = rx_ctl_q ? rts_flag_q : !man_q;

  // R9: request is withdrawn only on a start bit seen with the FIFO full
  a_r9_rts_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_flag_q) |-> ($past(fifo_full) && $past(rx_start)));
  // R10: a held byte never lingers while the FIFO has space
  a_r10_held_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (held_v_q && !fifo_full && !rx_bv) |=> !held_v_q);
endmodule

// File: tb/tb_uart_flow_top.sv
`timescale 1ns/1ps
module tb_uart_flow_top;
  localparam int CPS   = 4;
  localparam int DEPTH = 8;
  localparam int BIT   = 16 * CPS;
  localparam int CHAR  = 10 * BIT;
  localparam int NLOOP = DEPTH + 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_wr, rx_rd, mode_wr;
  logic [7:0] tx_din;
  logic [2:0] mode_din;
  logic       tx_hold_full, rx_valid, txd, rxd, rtsn, ctsn;
  logic [7:0] rx_data;
  logic       loop_sel, bench_rxd;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [7:0] expq[$];
  logic       m_rx_ctl, m_man;

  always #2 clk = ~clk;

  assign rxd  = loop_sel ? txd : bench_rxd;
  assign ctsn = rtsn;

  uart_flow_top #(.CLK_PER_SAMPLE(CPS), .RX_DEPTH(DEPTH), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .tx_wr_i(tx_wr), .tx_data_i(tx_din),
    .tx_hold_full_o(tx_hold_full), .rx_rd_i(rx_rd), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .mode_wr_i(mode_wr), .mode_data_i(mode_din),
    .txd_o(txd), .rxd_i(rxd), .rtsn_o(rtsn), .ctsn_i(ctsn)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // reference model: mode bits and transmit order, updated at the same edge as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rx_ctl <= 1'b0;
      m_man    <= 1'b0;
    end else begin
      if (mode_wr) begin
        m_rx_ctl <= mode_din[1];
        m_man    <= mode_din[2];
      end
      if (tx_wr && !tx_hold_full) expq.push_back(tx_din);
    end
  end

  // R5: per-clock comparison of the manual request level
  always @(negedge clk) begin
    if (rst_n === 1'b1 && cyc > 2 && !m_rx_ctl)
      check(rtsn === !m_man, "R5 manual rtsn", int'(rtsn), int'(!m_man));
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic [2:0] v);
    @(negedge clk);
    mode_wr  = 1'b1;
    mode_din = v;
    @(negedge clk);
    mode_wr  = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (tx_hold_full) @(negedge clk);
    tx_wr  = 1'b1;
    tx_din = b;
    @(negedge clk);
    tx_wr  = 1'b0;
  endtask

  task automatic read_one(input string tag);
    logic [7:0] e;
    @(negedge clk);
    check(rx_valid === 1'b1, tag, int'(rx_valid), 1);
    e = (expq.size() > 0) ? expq.pop_front() : 8'h00;
    check(rx_data === e, tag, int'(rx_data), int'(e));
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic drive_frame(input logic [7:0] b);
    bench_rxd = 1'b0;
    wait_clk(BIT);
    for (int i = 0; i < 8; i++) begin
      bench_rxd = b[i];
      wait_clk(BIT);
    end
    bench_rxd = 1'b1;
    wait_clk(BIT);
  endtask

  task automatic writer(input int n);
    for (int i = 0; i < n; i++) send(8'(8'h30 + i));
  endtask

  initial begin
    int got;
    int t;
    logic [7:0] fb;
    rst_n = 1'b0; tx_wr = 1'b0; rx_rd = 1'b0; mode_wr = 1'b0;
    tx_din = '0; mode_din = '0; loop_sel = 1'b1; bench_rxd = 1'b1;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);

    // R1 reset state
    check(txd === 1'b1, "R1 txd idle", int'(txd), 1);
    check(rtsn === 1'b1, "R1 rtsn negated", int'(rtsn), 1);
    check(rx_valid === 1'b0, "R1 rx empty", int'(rx_valid), 0);
    check(tx_hold_full === 1'b0, "R1 hold empty", int'(tx_hold_full), 0);

    // R4/R5 manual request, no gating
    set_mode(3'b100);
    @(negedge clk);
    check(rtsn === 1'b0, "R4 R5 manual assert", int'(rtsn), 0);

    // R2 frame shape on txd and loopback
    fb = 8'hB4;
    send(fb);
    t = 0;
    while (txd !== 1'b0 && t < 4 * BIT) begin @(negedge clk); t++; end
    wait_clk(BIT / 2);
    check(txd === 1'b0, "R2 start bit", int'(txd), 0);
    for (int i = 0; i < 8; i++) begin
      wait_clk(BIT);
      check(txd === fb[i], "R2 data bit", int'(txd), int'(fb[i]));
    end
    wait_clk(BIT);
    check(txd === 1'b1, "R2 stop bit", int'(txd), 1);
    wait_clk(BIT);
    read_one("R2 loopback byte");
    send(8'hA5);
    send(8'h3C);
    wait_clk(3 * CHAR);
    read_one("R2 order first");
    read_one("R2 order second");

    // R6 ctsn high but gating off
    set_mode(3'b000);
    @(negedge clk);
    check(rtsn === 1'b1, "R5 manual negate", int'(rtsn), 1);
    send(8'h81);
    wait_clk(2 * CHAR);
    read_one("R6 cts ignored");

    // R7 gating holds the byte
    set_mode(3'b001);
    send(8'h42);
    got = 0;
    for (int i = 0; i < 2 * CHAR; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) got++;
    end
    check(got == 0, "R7 txd stays high", got, 0);
    check(rx_valid === 1'b0, "R7 nothing received", int'(rx_valid), 0);
    set_mode(3'b101);
    wait_clk(2 * CHAR);
    read_one("R7 sent after cts");

    // R8 negate mid character
    send(8'h99);
    send(8'h66);
    t = 0;
    while (txd !== 1'b0 && t < 4 * CHAR) begin @(negedge clk); t++; end
    wait_clk(3 * BIT);
    set_mode(3'b001);
    wait_clk(3 * CHAR);
    read_one("R8 current char completes");
    @(negedge clk);
    check(rx_valid === 1'b0, "R8 next char withheld", int'(rx_valid), 0);
    check(tx_hold_full === 1'b1, "R8 byte waits in holding", int'(tx_hold_full), 1);
    set_mode(3'b101);
    wait_clk(2 * CHAR);
    read_one("R8 withheld byte later");

    // R3 glitch rejection and bench-driven frame
    loop_sel = 1'b0;
    wait_clk(4);
    bench_rxd = 1'b0;
    wait_clk(3 * CPS);
    bench_rxd = 1'b1;
    wait_clk(2 * CHAR);
    check(rx_valid === 1'b0, "R3 glitch rejected", int'(rx_valid), 0);
    expq.push_back(8'hC3);
    drive_frame(8'hC3);
    wait_clk(BIT);
    read_one("R3 valid frame");
    loop_sel = 1'b1;
    wait_clk(BIT);

    // R9 R10 R11 R12 closed loop with reads withheld
    set_mode(3'b011);
    @(negedge clk);
    check(rtsn === 1'b0, "R9 receiver owns rtsn", int'(rtsn), 0);
    fork
      writer(NLOOP);
    join_none
    wait_clk((DEPTH + 4) * CHAR);
    check(rtsn === 1'b1, "R9 rtsn negated when full", int'(rtsn), 1);
    check(tx_hold_full === 1'b1, "R9 transmitter stalled", int'(tx_hold_full), 1);
    check(expq.size() == DEPTH + 2, "R12 bytes written at stall", expq.size(), DEPTH + 2);
    got = 0;
    while (1) begin
      @(negedge clk);
      if (got == 1) check(rtsn === 1'b0, "R10 rtsn reasserted after read", int'(rtsn), 0);
      if (!rx_valid) begin
        rx_rd = 1'b0;
        break;
      end
      fb = (expq.size() > 0) ? expq.pop_front() : 8'h00;
      check(rx_data === fb, "R11 burst order", int'(rx_data), int'(fb));
      rx_rd = 1'b1;
      got++;
    end
    check(got == DEPTH + 1, "R12 held count", got, DEPTH + 1);
    for (int i = got; i < NLOOP; i++) begin
      wait_clk(3 * CHAR);
      read_one("R11 delayed read");
    end
    wait_clk(2 * CHAR);
    check(rx_valid === 1'b0, "R11 nothing extra", int'(rx_valid), 0);
    check(expq.size() == 0, "R11 no byte lost", expq.size(), 0);

    finish_run();
  end
endmodule